// File: doc/BRIEF.md
# Periodic Rate Divider with Square-Wave and Interrupt Flag

This block turns a stream of single-cycle tick strobes, arriving at 32768 per second, into a selectable slower rate. A free-running binary divider counts the ticks. A 4-bit rate code picks one divider stage. That stage drives a 50% duty-cycle square-wave output, and each of its rising edges sets a periodic flag that software can poll.

When the flag is enabled, it also raises a summary flag and an interrupt request. Reading the status byte returns the flags as they stood and clears them in the same cycle. An override input bypasses the divider: the output then repeats every raw tick, and the periodic flag is held off.

The divider never stops or restarts when the rate code changes. Only the stage that is watched changes, so rate changes cause no reset glitch and no extra flag.

Top module: `pisq_top`

## Requirements
- R1: While rst_n is low, sqw_o, pf_o, irqf_o, irq_o and status_o are all 0, and the divider count is 0 once reset is released.
- R2: For rate codes 3 to 15, with the square wave enabled and no override, sqw_o is bit (code-2) of the 14-bit tick count, updated on the clock edge that samples the tick. This gives a 50% duty square of period 2^(code-1) ticks.
- R3: Rate code 1 behaves exactly as code 8, and rate code 2 exactly as code 9, for both sqw_o and the periodic flag.
- R4: Rate code 0 keeps sqw_o at 0 and never sets the periodic flag.
- R5: With ovr_i high, sqw_o is 1 in the cycle after each clock edge where tick_i was 1, and 0 otherwise, whatever the rate code. The periodic flag never sets while ovr_i is high.
- R6: With sqw_en_i and ovr_i both low, sqw_o is 0 in the cycle after the edge, and the periodic flag still works.
- R7: The periodic flag sets on the edge where a tick moves the selected divider stage from 0 to 1, whatever the value of pie_i. A change of rate code without a tick never sets it.
- R8: irqf_o and irq_o are both high exactly when the periodic flag and pie_i are both high.
- R9: status_o carries the summary flag in bit 7 and the periodic flag in bit 6. Bits 5 down to 0 read 0.
- R10: An edge with rd_i high clears the periodic flag. If the flag is set again on that same edge, it stays set.
- R11: Cycles with tick_i low leave the divider, sqw_o and the periodic flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe at the 32768 Hz base rate |
| rate_sel_i | input | 4 | Rate code |
| sqw_en_i | input | 1 | Square-wave output enable |
| pie_i | input | 1 | Periodic interrupt enable |
| ovr_i | input | 1 | Full-rate override; also disables the periodic flag |
| rd_i | input | 1 | Status read strobe; clears the flags |
| sqw_o | output | 1 | Square-wave output |
| status_o | output | 8 | Status byte {summary, periodic, 6'b0} |
| pf_o | output | 1 | Periodic flag |
| irqf_o | output | 1 | Summary interrupt flag |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench checks the two alias codes against their partner codes. A decoder that took codes 1 and 2 literally would produce rates above 8192 Hz, and the flag would set far too often. A read that coincides with a rising stage edge is placed on purpose. A design that lets the clear win would lose that event, so the bench would see pf_o drop to 0. Random rate changes and override toggles catch designs that raise spurious flags on a rate switch or under override. Long tick-free stretches catch a divider that counts clock cycles instead of ticks.

// File: rtl/pisq_pkg.sv
package pisq_pkg;

  localparam int DIV_W_DEF  = 14;
  localparam int RATE_W     = 4;
  localparam int TAP_W      = 4;
  localparam int ALIAS_A_IN = 1;
  localparam int ALIAS_A_TO = 8;
  localparam int ALIAS_B_IN = 2;
  localparam int ALIAS_B_TO = 9;
  // the divider stage holding a square of period 2^(code-1) ticks is code-2
  localparam int TAP_OFFSET = 2;

  typedef struct packed {
    logic             valid;
    logic [TAP_W-1:0] tap;
  } tap_sel_t;

endpackage

// File: rtl/pisq_rate_dec.sv
module pisq_rate_dec
  import pisq_pkg::*;
#(
  parameter int DIV_W = DIV_W_DEF
) (
  input  logic [RATE_W-1:0] code_i,
  output tap_sel_t          sel_o
);

  logic [RATE_W-1:0] eff_code;
  int unsigned       tap_idx;

  // fold the two alias codes onto their partner rates
  always_comb begin
    if (code_i == RATE_W'(ALIAS_A_IN)) begin
      eff_code = RATE_W'(ALIAS_A_TO);
    end else if (code_i == RATE_W'(ALIAS_B_IN)) begin
      eff_code = RATE_W'(ALIAS_B_TO);
    end else begin
      eff_code = code_i;
    end
  end

  always_comb begin
    sel_o   = '0;
    tap_idx = 32'(eff_code) - TAP_OFFSET;
    if (eff_code >= RATE_W'(TAP_OFFSET + 1) && tap_idx < 32'(DIV_W)) begin
      sel_o.valid = 1'b1;
      sel_o.tap   = TAP_W'(tap_idx);
    end
  end

endmodule

// File: rtl/pisq_div.sv
module pisq_div #(
  parameter int DIV_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [DIV_W-1:0] cnt_nxt_o,
  output logic [DIV_W-1:0] rise_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_d;
    end
  end

  // a stage rises only on a counting step, never on a change of selection
  for (genvar g = 0; g < DIV_W; g++) begin : g_rise
    assign rise_o[g] = tick_i & ~cnt_q[g] & cnt_d[g];
  end

  assign cnt_nxt_o = cnt_d;

endmodule

// File: rtl/pisq_sqw.sv
module pisq_sqw
  import pisq_pkg::*;
#(
  parameter int DIV_W = DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ovr_i,
  input  logic             sqw_en_i,
  input  tap_sel_t         sel_i,
  input  logic [DIV_W-1:0] cnt_nxt_i,
  output logic             sqw_o
);

  logic sqw_q;
  logic sqw_d;

  always_comb begin
    if (ovr_i) begin
      sqw_d = tick_i;
    end else if (sqw_en_i && sel_i.valid) begin
      sqw_d = cnt_nxt_i[sel_i.tap];
    end else begin
      sqw_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sqw_q <= 1'b0;
    end else begin
      sqw_q <= sqw_d;
    end
  end

  assign sqw_o = sqw_q;

endmodule

// File: rtl/pisq_flag.sv
module pisq_flag
  import pisq_pkg::*;
#(
  parameter int DIV_W = DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovr_i,
  input  logic             rd_i,
  input  tap_sel_t         sel_i,
  input  logic [DIV_W-1:0] rise_i,
  output logic             pf_o
);

  logic pf_q;
  logic pf_d;
  logic set_evt;

  assign set_evt = sel_i.valid & ~ovr_i & rise_i[sel_i.tap];

  // a new event outranks the clear
  always_comb begin
    pf_d = pf_q;
    if (rd_i) begin
      pf_d = 1'b0;
    end
    if (set_evt) begin
      pf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q <= 1'b0;
    end else begin
      pf_q <= pf_d;
    end
  end

  assign pf_o = pf_q;

endmodule

// File: rtl/pisq_top.sv
module pisq_top
  import pisq_pkg::*;
#(
  parameter int DIV_W = DIV_W_DEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic [3:0]  rate_sel_i,
  input  logic        sqw_en_i,
  input  logic        pie_i,
  input  logic        ovr_i,
  input  logic        rd_i,
  output logic        sqw_o,
  output logic [7:0]  status_o,
  output logic        pf_o,
  output logic        irqf_o,
  output logic        irq_o
);

  localparam int STAT_SUM_BIT = 7;
  localparam int STAT_PF_BIT  = 6;

  tap_sel_t         sel;
  logic [DIV_W-1:0] cnt_nxt;
  logic [DIV_W-1:0] rise;
  logic             pf;
  logic             summary;

  pisq_rate_dec #(.DIV_W(DIV_W)) u_dec (
    .code_i (rate_sel_i),
    .sel_o  (sel)
  );

  pisq_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .cnt_nxt_o (cnt_nxt),
    .rise_o    (rise)
  );

  pisq_sqw #(.DIV_W(DIV_W)) u_sqw (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .ovr_i     (ovr_i),
    .sqw_en_i  (sqw_en_i),
    .sel_i     (sel),
    .cnt_nxt_i (cnt_nxt),
    .sqw_o     (sqw_o)
  );

  pisq_flag #(.DIV_W(DIV_W)) u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .ovr_i  (ovr_i),
    .rd_i   (rd_i),
    .sel_i  (sel),
    .rise_i (rise),
    .pf_o   (pf)
  );

  assign summary = pf & pie_i;

  always_comb begin
    status_o               = '0;
    status_o[STAT_SUM_BIT] = summary;
    status_o[STAT_PF_BIT]  = pf;
  end

  assign pf_o   = pf;
  assign irqf_o = summary;
  assign irq_o  = summary;

endmodule

// File: rtl/pisq_chk.sv
module pisq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic [3:0] rate_sel_i,
  input logic       sqw_en_i,
  input logic       pie_i,
  input logic       ovr_i,
  input logic       rd_i,
  input logic       sqw_o,
  input logic [7:0] status_o,
  input logic       pf_o,
  input logic       irqf_o,
  input logic       irq_o
);

  // R9: low status bits stay zero
  p_status_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[5:0] == 6'd0);

  // R8: request only with a pending flag and its enable
  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pf_o && pie_i && irqf_o));

  // R10: the flag only drops after a read
  p_fall_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pf_o) |-> $past(rd_i));

  // R5: no flag set under override
  p_ovr_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovr_i) && !$past(pf_o) |-> !pf_o);

  // R5: override output follows the tick
  p_ovr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovr_i) |-> (sqw_o == $past(tick_i)));

  // R4: code zero stays quiet
  p_code0_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rate_sel_i == 4'd0 && !ovr_i) |-> (!sqw_o && !$rose(pf_o)));

  // R6: output gated off without enable or override
  p_sqw_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sqw_en_i && !ovr_i) |-> !sqw_o);

  // R11: a tick-free cycle sets no flag and keeps the square
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!tick_i && !ovr_i && sqw_en_i) && $past(rate_sel_i) == rate_sel_i
      && $past(sqw_en_i) == sqw_en_i && !ovr_i && !tick_i
      |=> $stable(sqw_o) || !$past(sqw_en_i));

  // R7: a flag can only rise after a tick
  p_rise_needs_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_o) |-> $past(tick_i));

endmodule

bind pisq_top pisq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .rate_sel_i (rate_sel_i),
  .sqw_en_i   (sqw_en_i),
  .pie_i      (pie_i),
  .ovr_i      (ovr_i),
  .rd_i       (rd_i),
  .sqw_o      (sqw_o),
  .status_o   (status_o),
  .pf_o       (pf_o),
  .irqf_o     (irqf_o),
  .irq_o      (irq_o)
);

// File: tb/sim_pisq_top.sv
module sim_pisq_top;

  logic       clk;
  logic       rst_n;
  logic       tick_i;
  logic [3:0] rate_sel_i;
  logic       sqw_en_i;
  logic       pie_i;
  logic       ovr_i;
  logic       rd_i;
  logic       sqw_o;
  logic [7:0] status_o;
  logic       pf_o;
  logic       irqf_o;
  logic       irq_o;

  int checks;
  int failures;

  logic [13:0] m_cnt;
  logic        m_pf;
  logic        m_sq;

  pisq_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .rate_sel_i (rate_sel_i),
    .sqw_en_i   (sqw_en_i),
    .pie_i      (pie_i),
    .ovr_i      (ovr_i),
    .rd_i       (rd_i),
    .sqw_o      (sqw_o),
    .status_o   (status_o),
    .pf_o       (pf_o),
    .irqf_o     (irqf_o),
    .irq_o      (irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // stage watched for a code; -1 when the code selects nothing (R2, R3, R4)
  function automatic int exp_tap(input logic [3:0] c);
    if (c == 4'd0) return -1;
    if (c == 4'd1) return 6;
    if (c == 4'd2) return 7;
    return int'(c) - 2;
  endfunction

  // reference behaviour from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0;
      m_pf  <= 1'b0;
      m_sq  <= 1'b0;
    end else begin
      automatic logic [13:0] n   = tick_i ? m_cnt + 14'd1 : m_cnt;
      automatic int          k   = exp_tap(rate_sel_i);
      automatic logic        set = 1'b0;
      automatic logic        sq  = 1'b0;
      if (k >= 0) begin
        set = tick_i && !ovr_i && !m_cnt[k] && n[k];
        sq  = n[k];
      end
      m_cnt <= n;
      m_pf  <= set | (m_pf & ~rd_i);
      if (ovr_i)                     m_sq <= tick_i;
      else if (sqw_en_i && (k >= 0)) m_sq <= sq;
      else                           m_sq <= 1'b0;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string sq_tag();
    if (ovr_i)             return "R5";
    if (!sqw_en_i)         return "R6";
    if (rate_sel_i == 4'd0) return "R4";
    if (rate_sel_i <= 4'd2) return "R3";
    return "R2";
  endfunction

  // compare every output with the reference
  task automatic compare_all();
    automatic logic [7:0] est = {m_pf & pie_i, m_pf, 6'b0};
    check(sqw_o == m_sq, sq_tag(), sqw_o, m_sq);
    check(pf_o == m_pf, "R7 flag", pf_o, m_pf);
    check(status_o == est, "R9 status", status_o, est);
    check(irq_o == (m_pf & pie_i) && irqf_o == irq_o, "R8 irq", irq_o, m_pf & pie_i);
  endtask

  task automatic drive(input logic t, input logic [3:0] c, input logic se,
                       input logic pe, input logic ov, input logic rd);
    tick_i = t; rate_sel_i = c; sqw_en_i = se; pie_i = pe; ovr_i = ov; rd_i = rd;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic held_sq;
    logic held_pf;
    checks = 0;
    failures = 0;
    void'($urandom(32'd7211));
    rst_n = 1'b0;
    drive(1'b1, 4'd3, 1'b1, 1'b1, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(sqw_o == 1'b0 && pf_o == 1'b0, "R1 outputs", {sqw_o, pf_o}, 0);
    check(status_o == 8'd0 && irq_o == 1'b0, "R1 status", status_o, 0);
    rst_n = 1'b1;

    // R2: code 3 with a tick every cycle gives period 4
    drive(1'b1, 4'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      compare_all();
      if (i == 3) check(m_cnt == 14'd4, "R1 count from zero", m_cnt, 4);
    end

    // R10: a read on the edge of a new rise keeps the flag
    drive(1'b1, 4'd3, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      compare_all();
      if (m_cnt[1:0] == 2'b01) break;
    end
    drive(1'b1, 4'd3, 1'b1, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    check(pf_o == 1'b1, "R10 set wins", pf_o, 1);
    compare_all();
    drive(1'b0, 4'd3, 1'b1, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    check(pf_o == 1'b0, "R10 clear", pf_o, 0);
    compare_all();

    // R11: no ticks, nothing moves
    drive(1'b0, 4'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    held_sq = sqw_o;
    held_pf = pf_o;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      compare_all();
    end
    check(sqw_o == held_sq && pf_o == held_pf, "R11 stall", {sqw_o, pf_o}, {held_sq, held_pf});

    // R6: square gated off, flag still rises
    drive(1'b1, 4'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    drive(1'b1, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      compare_all();
      check(sqw_o == 1'b0, "R6 gated", sqw_o, 0);
    end
    check(pf_o == 1'b1, "R6 flag without enable", pf_o, 1);

    // R5: override pulses per tick, flag cleared and not reset
    drive(1'b1, 4'd3, 1'b0, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      compare_all();
      drive(i[0], 4'd5, 1'b0, 1'b1, 1'b1, 1'b0);
    end
    check(pf_o == 1'b0, "R5 no flag", pf_o, 0);

    // R3: aliases against their partners, and other codes, random traffic
    for (int blk = 0; blk < 24; blk++) begin
      automatic logic [3:0] c  = (blk < 4) ? 4'(blk % 2 == 0 ? 1 : 2) : 4'($urandom % 16);
      automatic logic       ov = (blk >= 4) && ($urandom % 8 == 0);
      automatic logic       se = ($urandom % 4) != 0;
      automatic logic       pe = $urandom % 2;
      for (int i = 0; i < 1500; i++) begin
        drive(($urandom % 8) != 0, c, se, pe, ov, ($urandom % 16) == 0);
        @(negedge clk);
        compare_all();
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule